// File: doc/BRIEF.md
# Load-Store Ordering Violation Detector

This block sits beside an out-of-order core and keeps in-flight loads and stores in two circular queues, each entry claimed at allocation in fetch order. The core executes memory operations in any order and reports each one's address to the block. When a store executes, the block looks for any younger load to the same memory word that has already executed. Such a load may have read stale data. The block then requests a squash that starts at the oldest such load, drops that load and every younger queue entry, and records the load's instruction address in a small one-bit-per-entry "wait" table.

Before issuing a load, the scheduler asks whether that load may go. A load whose instruction address is marked in the wait table may not issue until every older store has executed. Unmarked loads always may. A free-running timer wipes the whole table at a fixed interval, so stale marks do not hold back loads for ever. Entries leave the queues only at retirement. A retiring store is the moment its word is written to memory, and the block reports that write.

Top module: `lsq_order_guard`

## Requirements
- R1: An accepted allocation (`alloc_vld` and `alloc_ready` both 1) takes the next entry of the load queue (`alloc_store`=0) or the store queue (`alloc_store`=1). `alloc_idx` returns that entry's index, which advances by one modulo 32 per allocation into that queue.
- R2: `alloc_ready` is 0 when the queue selected by `alloc_store` holds 32 entries. It stays 1 for the other queue if that queue has room.
- R3: When a store executes, each executed load that is younger than it and has the same word address (address bits above bit 1) is a violation. One cycle later `squash_vld` is 1, with that load's instruction address on `squash_pc` and its load-queue index on `squash_idx`.
- R4: A store execution raises no squash for a load that is older than the store, for a load that has not executed, or for a load whose word address differs.
- R5: When several younger executed loads match, the squash names the oldest of them in program order.
- R6: A squash frees the named load and every younger entry in both queues. The next load allocation therefore receives the named load's index.
- R7: `alloc_ready` is 0 in the cycle a violation is detected and in the following cycle, while `squash_vld` is 1.
- R8: Retiring a store (`ret_vld`=1, `ret_store`=1) frees the oldest store entry. One cycle later `mem_wr_vld` is 1 and `mem_wr_addr` holds the store's word-aligned address. Retiring a load frees the oldest load entry and produces no write.
- R9: A violation marks the wait-table entry selected by instruction-address bits [7:2] of the offending load. A load queried through `ld_q_idx` whose address selects a marked entry gets `ld_may_issue`=0 while any older store in the queue has not executed.
- R10: `ld_may_issue` is 1 for a load whose wait-table entry is unmarked, and for a marked load once every older store has executed.
- R11: Every wait-table mark is cleared once every 16,384 cycles by a timer that runs from reset.
- R12: After reset both queues are empty, the wait table is clear, `squash_vld` and `mem_wr_vld` are 0, and `alloc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate one memory operation this cycle |
| alloc_store | input | 1 | 1: store, 0: load |
| alloc_pc | input | 32 | Instruction address of the allocated operation |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | 5 | Queue index given to the allocated operation |
| ld_exec_vld | input | 1 | A load has produced its address |
| ld_exec_idx | input | 5 | Load-queue index of that load |
| ld_exec_addr | input | 32 | Byte address of that load |
| st_exec_vld | input | 1 | A store has produced its address |
| st_exec_idx | input | 5 | Store-queue index of that store |
| st_exec_addr | input | 32 | Byte address of that store |
| ret_vld | input | 1 | Retire the oldest operation of one queue |
| ret_store | input | 1 | 1: retire oldest store, 0: retire oldest load |
| mem_wr_vld | output | 1 | A retired store writes memory |
| mem_wr_addr | output | 32 | Word-aligned address of that write |
| squash_vld | output | 1 | Ordering violation: restart from the named load |
| squash_idx | output | 5 | Load-queue index of the named load |
| squash_pc | output | 32 | Instruction address to refetch from |
| ld_q_idx | input | 5 | Load-queue index being asked about |
| ld_may_issue | output | 1 | The asked-about load may issue now |

## Verification
The assertions watch cause and effect on every cycle. A squash appears only after a store execution. No allocation is accepted while a squash is visible. A memory write appears only after a store retirement and never after a load retirement. Reset leaves the block quiet. The bench scenarios cover what depends on order and history: which of several matching loads is named, that older, unexecuted and other-word loads are left alone, that the queue index is reused after a squash, that a trained load is held and then released by store execution, and that the periodic wipe frees it.

// File: rtl/lsq_order_pkg.sv
package lsq_order_pkg;
    localparam int unsigned DEPTH        = 32;
    localparam int unsigned ADDR_W       = 32;
    localparam int unsigned PC_W         = 32;
    localparam int unsigned TBL_ENTRIES  = 64;
    localparam int unsigned CLEAR_PERIOD = 16384;

    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned SEQ_W = $clog2(2 * DEPTH) + 1;
    localparam int unsigned TBL_W = $clog2(TBL_ENTRIES);
    localparam int unsigned TMR_W = $clog2(CLEAR_PERIOD);
    localparam int unsigned WRD_W = ADDR_W - 2;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [IDX_W:0]   ptr_t;
    typedef logic [WRD_W-1:0] word_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        seq_t  seq;
        pc_t   pc;
        word_t word;
        logic  done;
    } ld_ent_t;

    typedef struct packed {
        seq_t  seq;
        word_t word;
        logic  done;
    } st_ent_t;

    // a was allocated before b (modular age compare)
    function automatic logic seq_older(seq_t a, seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    function automatic word_t word_of(logic [ADDR_W-1:0] addr);
        return addr[ADDR_W-1:2];
    endfunction

    function automatic logic [TBL_W-1:0] tbl_slot(pc_t pc);
        return pc[TBL_W+1:2];
    endfunction
endpackage

// File: rtl/lsq_delay_table.sv
module lsq_delay_table
    import lsq_order_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic train_en,
    input  pc_t  train_pc,
    input  pc_t  look_pc,
    output logic look_marked
);
    logic [TBL_ENTRIES-1:0] marks_q, marks_d;
    logic [TMR_W-1:0]       tmr_q;
    logic                   wipe;

    assign wipe        = (tmr_q == TMR_W'(CLEAR_PERIOD - 1));
    assign look_marked = marks_q[tbl_slot(look_pc)];

    always_comb begin
        marks_d = wipe ? '0 : marks_q;
        if (train_en) begin
            marks_d[tbl_slot(train_pc)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            marks_q <= '0;
            tmr_q   <= '0;
        end else begin
            marks_q <= marks_d;
            tmr_q   <= wipe ? '0 : tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/lsq_load_queue.sv
module lsq_load_queue
    import lsq_order_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_en,
    input  seq_t  alloc_seq,
    input  pc_t   alloc_pc,
    output idx_t  tail_idx,
    output logic  full,
    input  logic  exec_en,
    input  idx_t  exec_idx,
    input  word_t exec_word,
    input  logic  ret_en,
    input  logic  chk_en,
    input  seq_t  chk_seq,
    input  word_t chk_word,
    output logic  hit,
    output ptr_t  hit_ptr,
    output seq_t  hit_seq,
    output pc_t   hit_pc,
    input  idx_t  q_idx,
    output seq_t  q_seq,
    output pc_t   q_pc
);
    ld_ent_t ents [DEPTH];
    ptr_t    head_q, tail_q, occ, hit_off;

    assign occ      = tail_q - head_q;
    assign full     = occ[IDX_W];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign q_seq    = ents[q_idx].seq;
    assign q_pc     = ents[q_idx].pc;

    // oldest-first scan: the first match from the head wins
    always_comb begin
        hit     = 1'b0;
        hit_off = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!hit && chk_en && (ptr_t'(k) < occ)
                && ents[head_q[IDX_W-1:0] + idx_t'(k)].done
                && (ents[head_q[IDX_W-1:0] + idx_t'(k)].word == chk_word)
                && seq_older(chk_seq, ents[head_q[IDX_W-1:0] + idx_t'(k)].seq)) begin
                hit     = 1'b1;
                hit_off = ptr_t'(k);
            end
        end
    end

    assign hit_ptr = head_q + hit_off;
    assign hit_seq = ents[hit_ptr[IDX_W-1:0]].seq;
    assign hit_pc  = ents[hit_ptr[IDX_W-1:0]].pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
            end
        end else begin
            if (ret_en) begin
                head_q <= head_q + 1'b1;
            end
            if (hit) begin
                tail_q <= hit_ptr;
            end else if (alloc_en) begin
                ents[tail_idx] <= '{seq: alloc_seq, pc: alloc_pc, word: '0, done: 1'b0};
                tail_q         <= tail_q + 1'b1;
            end
            if (exec_en) begin
                ents[exec_idx].done <= 1'b1;
                ents[exec_idx].word <= exec_word;
            end
        end
    end
endmodule

// File: rtl/lsq_store_queue.sv
module lsq_store_queue
    import lsq_order_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_en,
    input  seq_t  alloc_seq,
    output idx_t  tail_idx,
    output logic  full,
    input  logic  exec_en,
    input  idx_t  exec_idx,
    input  word_t exec_word,
    output seq_t  exec_seq,
    input  logic  ret_en,
    output word_t head_word,
    input  logic  trunc_en,
    input  seq_t  trunc_seq,
    input  seq_t  q_seq,
    output logic  older_pending
);
    st_ent_t ents [DEPTH];
    ptr_t    head_q, tail_q, occ, keep_cnt;

    assign occ       = tail_q - head_q;
    assign full      = occ[IDX_W];
    assign tail_idx  = tail_q[IDX_W-1:0];
    assign exec_seq  = ents[exec_idx].seq;
    assign head_word = ents[head_q[IDX_W-1:0]].word;

    always_comb begin
        keep_cnt      = '0;
        older_pending = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ptr_t'(k) < occ) begin
                if (seq_older(ents[head_q[IDX_W-1:0] + idx_t'(k)].seq, trunc_seq)) begin
                    keep_cnt = keep_cnt + 1'b1;
                end
                if (seq_older(ents[head_q[IDX_W-1:0] + idx_t'(k)].seq, q_seq)
                    && !ents[head_q[IDX_W-1:0] + idx_t'(k)].done) begin
                    older_pending = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
            end
        end else begin
            if (ret_en) begin
                head_q <= head_q + 1'b1;
            end
            if (trunc_en) begin
                tail_q <= head_q + keep_cnt;
            end else if (alloc_en) begin
                ents[tail_idx] <= '{seq: alloc_seq, word: '0, done: 1'b0};
                tail_q         <= tail_q + 1'b1;
            end
            if (exec_en) begin
                ents[exec_idx].done <= 1'b1;
                ents[exec_idx].word <= exec_word;
            end
        end
    end
endmodule

// File: rtl/lsq_order_guard.sv
module lsq_order_guard
    import lsq_order_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_vld,
    input  logic              alloc_store,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              ld_exec_vld,
    input  logic [IDX_W-1:0]  ld_exec_idx,
    input  logic [ADDR_W-1:0] ld_exec_addr,
    input  logic              st_exec_vld,
    input  logic [IDX_W-1:0]  st_exec_idx,
    input  logic [ADDR_W-1:0] st_exec_addr,
    input  logic              ret_vld,
    input  logic              ret_store,
    output logic              mem_wr_vld,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic              squash_vld,
    output logic [IDX_W-1:0]  squash_idx,
    output logic [PC_W-1:0]   squash_pc,
    input  logic [IDX_W-1:0]  ld_q_idx,
    output logic              ld_may_issue
);
    seq_t  seq_q, st_seq, hit_seq, q_seq;
    idx_t  lq_tail, sq_tail;
    logic  lq_full, sq_full, viol, alloc_go, older_pending, marked;
    ptr_t  hit_ptr;
    pc_t   hit_pc, q_pc;
    word_t sq_head_word;

    assign alloc_ready = !(alloc_store ? sq_full : lq_full) && !viol && !squash_vld;
    assign alloc_go    = alloc_vld && alloc_ready;
    assign alloc_idx   = alloc_store ? sq_tail : lq_tail;

    lsq_load_queue u_lq (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_go && !alloc_store), .alloc_seq(seq_q), .alloc_pc(alloc_pc),
        .tail_idx(lq_tail), .full(lq_full),
        .exec_en(ld_exec_vld), .exec_idx(ld_exec_idx), .exec_word(word_of(ld_exec_addr)),
        .ret_en(ret_vld && !ret_store),
        .chk_en(st_exec_vld), .chk_seq(st_seq), .chk_word(word_of(st_exec_addr)),
        .hit(viol), .hit_ptr(hit_ptr), .hit_seq(hit_seq), .hit_pc(hit_pc),
        .q_idx(ld_q_idx), .q_seq(q_seq), .q_pc(q_pc)
    );

    lsq_store_queue u_sq (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_go && alloc_store), .alloc_seq(seq_q),
        .tail_idx(sq_tail), .full(sq_full),
        .exec_en(st_exec_vld), .exec_idx(st_exec_idx), .exec_word(word_of(st_exec_addr)),
        .exec_seq(st_seq),
        .ret_en(ret_vld && ret_store), .head_word(sq_head_word),
        .trunc_en(viol), .trunc_seq(hit_seq),
        .q_seq(q_seq), .older_pending(older_pending)
    );

    lsq_delay_table u_tbl (
        .clk(clk), .rst(rst),
        .train_en(viol), .train_pc(hit_pc),
        .look_pc(q_pc), .look_marked(marked)
    );

    assign ld_may_issue = !marked || !older_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q       <= '0;
            squash_vld  <= 1'b0;
            squash_idx  <= '0;
            squash_pc   <= '0;
            mem_wr_vld  <= 1'b0;
            mem_wr_addr <= '0;
        end else begin
            if (viol) begin
                seq_q <= hit_seq;
            end else if (alloc_go) begin
                seq_q <= seq_q + 1'b1;
            end
            squash_vld  <= viol;
            squash_idx  <= hit_ptr[IDX_W-1:0];
            squash_pc   <= hit_pc;
            mem_wr_vld  <= ret_vld && ret_store;
            mem_wr_addr <= {sq_head_word, 2'b00};
        end
    end
endmodule

// File: rtl/lsq_order_guard_chk.sv
module lsq_order_guard_chk (
    input logic clk,
    input logic rst,
    input logic alloc_ready,
    input logic st_exec_vld,
    input logic ret_vld,
    input logic ret_store,
    input logic mem_wr_vld,
    input logic squash_vld
);
    AST_SQUASH_FROM_STORE: assert property (@(posedge clk) disable iff (rst)
        squash_vld |-> $past(st_exec_vld)); // R3
    AST_ALLOC_HELD_IN_SQUASH: assert property (@(posedge clk) disable iff (rst)
        squash_vld |-> !alloc_ready); // R7
    AST_WRITE_FROM_STORE_RETIRE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_vld |-> $past(ret_vld && ret_store)); // R8
    AST_LOAD_RETIRE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ret_vld && !ret_store) |=> !mem_wr_vld); // R8
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!squash_vld && !mem_wr_vld && alloc_ready)); // R12
endmodule

bind lsq_order_guard lsq_order_guard_chk u_chk (
    .clk(clk), .rst(rst), .alloc_ready(alloc_ready), .st_exec_vld(st_exec_vld),
    .ret_vld(ret_vld), .ret_store(ret_store), .mem_wr_vld(mem_wr_vld),
    .squash_vld(squash_vld)
);

// File: tb/lsq_order_guard_bench.sv
module lsq_order_guard_bench;
    import lsq_order_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_vld = 0, alloc_store = 0;
    logic [PC_W-1:0] alloc_pc = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_idx;
    logic ld_exec_vld = 0;
    logic [IDX_W-1:0] ld_exec_idx = '0;
    logic [ADDR_W-1:0] ld_exec_addr = '0;
    logic st_exec_vld = 0;
    logic [IDX_W-1:0] st_exec_idx = '0;
    logic [ADDR_W-1:0] st_exec_addr = '0;
    logic ret_vld = 0, ret_store = 0;
    logic mem_wr_vld, squash_vld, ld_may_issue;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [IDX_W-1:0] squash_idx;
    logic [PC_W-1:0] squash_pc;
    logic [IDX_W-1:0] ld_q_idx = '0;

    always #5 clk = ~clk;

    lsq_order_guard u_lsq_order_guard (.*);

    int n_chk = 0, n_err = 0;
    int lq_t = 0, sq_t = 0;

    typedef struct { logic [PC_W-1:0] pc; int idx; } sq_exp_t;
    sq_exp_t     exp_squash[$];
    logic [31:0] exp_write[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // monitor: pops scoreboard entries as the design reports events
    always @(negedge clk) begin
        if (!rst) begin
            if (squash_vld) begin
                if (exp_squash.size() == 0) begin
                    chk(0, "R4 unexpected squash", squash_pc, 0);
                end else begin
                    sq_exp_t e;
                    e = exp_squash.pop_front();
                    chk(squash_pc == e.pc, "R3 squash pc", squash_pc, e.pc);
                    chk(int'(squash_idx) == e.idx, "R5 squash index", squash_idx, e.idx);
                end
            end
            if (mem_wr_vld) begin
                if (exp_write.size() == 0) begin
                    chk(0, "R8 unexpected write", mem_wr_addr, 0);
                end else begin
                    logic [31:0] w;
                    w = exp_write.pop_front();
                    chk(mem_wr_addr == w, "R8 write address", mem_wr_addr, w);
                end
            end
        end
    end

    task automatic clr();
        alloc_vld = 0; ld_exec_vld = 0; st_exec_vld = 0; ret_vld = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); clr();
        end
    endtask

    task automatic alloc(input logic st, input logic [31:0] pc, output int idx);
        @(negedge clk); clr();
        alloc_vld = 1; alloc_store = st; alloc_pc = pc;
        #1;
        idx = st ? sq_t : lq_t;
        chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
        chk(int'(alloc_idx) == idx, "R1 index", alloc_idx, idx);
        if (st) sq_t = (sq_t + 1) % DEPTH;
        else    lq_t = (lq_t + 1) % DEPTH;
    endtask

    task automatic ld_exec(input int idx, input logic [31:0] a);
        @(negedge clk); clr();
        ld_exec_vld = 1; ld_exec_idx = IDX_W'(idx); ld_exec_addr = a;
    endtask

    task automatic st_exec(input int idx, input logic [31:0] a);
        @(negedge clk); clr();
        st_exec_vld = 1; st_exec_idx = IDX_W'(idx); st_exec_addr = a;
        #1;
    endtask

    task automatic retire(input logic st, input logic [31:0] wa);
        if (st) exp_write.push_back(wa);
        @(negedge clk); clr();
        ret_vld = 1; ret_store = st;
    endtask

    task automatic query(input int idx, input logic exp, input string req);
        @(negedge clk); clr();
        ld_q_idx = IDX_W'(idx);
        #1;
        chk(ld_may_issue == exp, req, ld_may_issue, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int s0, l0, l1, l2;
        sq_exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R12 reset state
        chk(alloc_ready == 1'b1, "R12 ready", alloc_ready, 1);
        chk(squash_vld == 1'b0, "R12 squash", squash_vld, 0);
        chk(mem_wr_vld == 1'b0, "R12 write", mem_wr_vld, 0);
        chk(ld_may_issue == 1'b1, "R12 may issue", ld_may_issue, 1);

        // plain traffic, different words: no squash (R4), write on store retire (R8)
        alloc(1, 32'h100, s0); alloc(0, 32'h104, l0);
        ld_exec(l0, 32'h80); st_exec(s0, 32'h40);
        retire(1, 32'h40); retire(0, 0);
        idle(2);

        // violation on same word, different byte (R3, R7, R9 training)
        alloc(1, 32'h200, s0); alloc(0, 32'h210, l0);
        ld_exec(l0, 32'h1000);
        e.pc = 32'h210; e.idx = l0; exp_squash.push_back(e);
        st_exec(s0, 32'h1002);
        chk(alloc_ready == 1'b0, "R7 detect cycle", alloc_ready, 0);
        idle(1); #1;
        chk(squash_vld && !alloc_ready, "R7 squash cycle", alloc_ready, 0);
        lq_t = l0;
        retire(1, 32'h1000);
        idle(2);

        // two matching younger loads: oldest named (R5), index reused (R6)
        alloc(1, 32'h2F0, s0); alloc(0, 32'h300, l1); alloc(0, 32'h304, l2);
        ld_exec(l2, 32'h2000); ld_exec(l1, 32'h2000);
        e.pc = 32'h300; e.idx = l1; exp_squash.push_back(e);
        st_exec(s0, 32'h2000);
        idle(2);
        lq_t = l1;
        retire(1, 32'h2000);

        // older load and other-word load: no squash (R4); first alloc checks R6 reuse
        alloc(0, 32'h400, l0);
        chk(l0 == l1, "R6 index reuse", l0, l1);
        alloc(1, 32'h404, s0); alloc(0, 32'h408, l2);
        ld_exec(l2, 32'h3004); ld_exec(l0, 32'h3000);
        st_exec(s0, 32'h3000);
        idle(2); #1;
        chk(squash_vld == 1'b0, "R4 no squash", squash_vld, 0);
        retire(0, 0); retire(1, 32'h3000); retire(0, 0);
        idle(2);

        // trained load held by older pending store (R9), released (R10)
        alloc(1, 32'h500, s0); alloc(0, 32'h210, l0); alloc(0, 32'h508, l1);
        query(l0, 1'b0, "R9 marked load held");
        query(l1, 1'b1, "R10 unmarked load free");
        st_exec(s0, 32'h5000);
        query(l0, 1'b1, "R10 released after stores");
        retire(1, 32'h5000); retire(0, 0); retire(0, 0);
        idle(2);

        // periodic wipe (R11)
        alloc(1, 32'h600, s0); alloc(0, 32'h210, l0);
        query(l0, 1'b0, "R9 still marked");
        idle(CLEAR_PERIOD + 20);
        query(l0, 1'b1, "R11 marks wiped");
        st_exec(s0, 32'h6000);
        retire(1, 32'h6000); retire(0, 0);
        idle(2);

        // fill load queue (R1 wrap, R2)
        for (int i = 0; i < DEPTH; i++) begin
            alloc(0, 32'h700 + 32'(4 * i), l0);
        end
        @(negedge clk); clr(); alloc_store = 0; #1;
        chk(alloc_ready == 1'b0, "R2 load queue full", alloc_ready, 0);
        alloc_store = 1; #1;
        chk(alloc_ready == 1'b1, "R2 store queue free", alloc_ready, 1);

        idle(3);
        chk(exp_squash.size() == 0, "R3 squash missing", exp_squash.size(), 0);
        chk(exp_write.size() == 0, "R8 write missing", exp_write.size(), 0);
        summary();
        $finish;
    end
endmodule